// File: doc/BRIEF.md
# External Interrupt Conditioning Unit

This block sits between seven external interrupt request pins and a vectored interrupt controller. Each pin is first brought into the clock domain. Then, according to a per-channel trigger setting, it is turned into an active-high level request. The controller therefore sees the same kind of signal on every line, whatever the pin's electrical convention.

Each channel can be set to one of four triggers: a high level, a low level, a rising edge or a falling edge. A level-triggered channel follows its pin, or the inverse of it, and stores nothing. An edge-triggered channel latches a sticky pending flag on the selected transition. The flag stays set until software clears it through a write-one-to-clear register.

Software reaches the block through an APB slave with zero wait states. Four word registers are available: trigger modes, pending clear, conditioned request state and synchronised raw pin state.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset every channel's trigger field reads 00, the pending register (offset 0x08) reads 0, and with all pins low every `irq_req` bit is 0.
- R2: Each pin passes through two flops before use. A pin change shows up in the raw register (offset 0x0C, bit i = channel i) and on a level-mode `irq_req` after exactly two rising clock edges.
- R3: Trigger code 00 (high level): `irq_req[i]` equals the synchronised pin.
- R4: Trigger code 01 (low level): `irq_req[i]` is the inverse of the synchronised pin.
- R5: Trigger code 10 (rising edge): a 0-to-1 change of the synchronised pin sets the pending flag. `irq_req[i]` goes high on the third rising edge after the pin change and stays high after the pin falls again.
- R6: Trigger code 11 (falling edge): the same behaviour as R5, but for a 1-to-0 change. With no change the output stays low.
- R7: Writing 1 to bit i of the clear register (offset 0x04) clears channel i's pending flag on that write. Bits written as 0 leave other channels' flags unchanged. The clear register reads as 0.
- R8: When an edge is detected in the same cycle as a clear of that channel, the flag remains set.
- R9: A write to the mode register that changes channel i's field clears channel i's pending flag. A write that keeps the same field leaves the flag unchanged.
- R10: The pending register (offset 0x08, bit i = channel i) returns the current `irq_req` vector.
- R11: The mode register (offset 0x00) holds channel i's trigger code in bits [2i+1:2i]. Higher bits read 0, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (APB clock) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data, zero outside a read |
| irq_pin | input | NUM_CH | Asynchronous external interrupt request pins |
| irq_req | output | NUM_CH | Active-high level requests to the interrupt controller |

## Verification
The bench builds the block with its defaults: seven channels, 32-bit data and an 8-bit address. The 14-bit mode field therefore leaves upper data bits whose read-as-zero behaviour can be seen, and one write can put all four trigger codes on different channels at once. With seven channels, the clear mask can be checked for the way it leaves other channels alone. Directed timing places an edge and a clear in the same cycle, and a behavioural model is compared on every clock during random pin and register traffic.

// File: rtl/eic_pkg.sv
package eic_pkg;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  // register word offsets (byte addresses)
  localparam int unsigned OFS_MODE  = 32'h00;
  localparam int unsigned OFS_CLEAR = 32'h04;
  localparam int unsigned OFS_PEND  = 32'h08;
  localparam int unsigned OFS_RAW   = 32'h0C;

endpackage

// File: rtl/eic_rst_sync.sv
module eic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= 2'b00;
    end else begin
      stg_q <= {stg_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stg_q[1];

endmodule

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_async;
    for (int s = 1; s < STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q[s] <= '0;
        end else begin
          stg_q[s] <= stg_d[s];
        end
      end
    end
  endgenerate

  assign q_sync = stg_q[STAGES-1];

endmodule

// File: rtl/eic_channel.sv
module eic_channel
  import eic_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  trig_e mode,
  input  logic  lvl_in,
  input  logic  clr,
  input  logic  mode_chg,
  output logic  irq
);

  logic prev_q;
  logic pend_q, pend_d;
  logic rise, fall, edge_hit;

  always_comb begin
    rise     = lvl_in & ~prev_q;
    fall     = ~lvl_in & prev_q;
    edge_hit = ((mode == TRIG_RISE) & rise) | ((mode == TRIG_FALL) & fall);
  end

  // priority: mode change, then edge, then software clear
  always_comb begin
    pend_d = pend_q;
    if (mode_chg) begin
      pend_d = 1'b0;
    end else if (edge_hit) begin
      pend_d = 1'b1;
    end else if (clr) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_in;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    unique case (mode)
      TRIG_HIGH: irq = lvl_in;
      TRIG_LOW:  irq = ~lvl_in;
      default:   irq = pend_q;
    endcase
  end

endmodule

// File: rtl/eic_apb_regs.sv
module eic_apb_regs
  import eic_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int MODE_W = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [NUM_CH-1:0] raw_vec,
  input  logic [NUM_CH-1:0] irq_vec,
  output logic [MODE_W-1:0] mode_q,
  output logic [NUM_CH-1:0] clr_vec,
  output logic [NUM_CH-1:0] mode_chg,
  output logic              mode_wr,
  output logic [DATA_W-1:0] prdata
);

  logic              wr_acc, rd_sel;
  logic              hit_mode, hit_clr, hit_pend, hit_raw;
  logic [MODE_W-1:0] mode_d;
  logic              mode_en;
  logic              wdata_unused;

  assign wdata_unused = ^pwdata[DATA_W-1:MODE_W];

  always_comb begin
    wr_acc   = psel & penable & pwrite;
    rd_sel   = psel & ~pwrite;
    hit_mode = (paddr == ADDR_W'(OFS_MODE));
    hit_clr  = (paddr == ADDR_W'(OFS_CLEAR));
    hit_pend = (paddr == ADDR_W'(OFS_PEND));
    hit_raw  = (paddr == ADDR_W'(OFS_RAW));
  end

  // mode register: next state and enable
  always_comb begin
    mode_en = wr_acc & hit_mode;
    mode_d  = mode_en ? pwdata[MODE_W-1:0] : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  assign mode_wr = mode_en;

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ctl
      assign mode_chg[i] = mode_en & (pwdata[2*i +: 2] != mode_q[2*i +: 2]);
      assign clr_vec[i]  = wr_acc & hit_clr & pwdata[i];
    end
  endgenerate

  always_comb begin
    prdata = '0;
    if (rd_sel) begin
      if (hit_mode) begin
        prdata[MODE_W-1:0] = mode_q;
      end else if (hit_pend) begin
        prdata[NUM_CH-1:0] = irq_vec;
      end else if (hit_raw) begin
        prdata[NUM_CH-1:0] = raw_vec;
      end
    end
  end

endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import eic_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [NUM_CH-1:0] irq_pin,
  output logic [NUM_CH-1:0] irq_req
);

  localparam int MODE_W = 2 * NUM_CH;

  logic              rst_sync_n;
  logic [NUM_CH-1:0] sync_q;
  logic [MODE_W-1:0] mode_q;
  logic [NUM_CH-1:0] clr_vec;
  logic [NUM_CH-1:0] mode_chg;
  logic              mode_wr;

  eic_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  eic_sync #(.W(NUM_CH), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .d_async (irq_pin),
    .q_sync  (sync_q)
  );

  eic_apb_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .raw_vec  (sync_q),
    .irq_vec  (irq_req),
    .mode_q   (mode_q),
    .clr_vec  (clr_vec),
    .mode_chg (mode_chg),
    .mode_wr  (mode_wr),
    .prdata   (prdata)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      eic_channel u_ch (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .mode     (trig_e'(mode_q[2*i +: 2])),
        .lvl_in   (sync_q[i]),
        .clr      (clr_vec[i]),
        .mode_chg (mode_chg[i]),
        .irq      (irq_req[i])
      );
    end
  endgenerate

endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
  parameter int NUM_CH = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2*NUM_CH-1:0] mode_q,
  input logic [NUM_CH-1:0]   sync_q,
  input logic [NUM_CH-1:0]   irq_req,
  input logic [NUM_CH-1:0]   clr_vec,
  input logic                mode_wr
);

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      AST_HIGH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[2*i +: 2] == 2'b00) |-> (irq_req[i] == sync_q[i])); // R3
      AST_LOW_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[2*i +: 2] == 2'b01) |-> (irq_req[i] != sync_q[i])); // R4
      AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[2*i+1] && irq_req[i] && !clr_vec[i] && !mode_wr) |=> irq_req[i]); // R5
      AST_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[2*i+1] && !irq_req[i] && (sync_q[i] == $past(sync_q[i])) && !mode_wr)
        |=> !irq_req[i]); // R6
      AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[2*i+1] && clr_vec[i] && (sync_q[i] == $past(sync_q[i])) && !mode_wr)
        |=> !irq_req[i]); // R7
      AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q[2*i +: 2] == 2'b10) && clr_vec[i] && sync_q[i] && !$past(sync_q[i]) && !mode_wr)
        |=> irq_req[i]); // R8
    end
  endgenerate

endmodule

bind ext_irq_cond eic_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .mode_q  (mode_q),
  .sync_q  (sync_q),
  .irq_req (irq_req),
  .clr_vec (clr_vec),
  .mode_wr (mode_wr)
);

// File: tb/sim_ext_irq_cond.sv
module sim_ext_irq_cond;

  localparam int NCH = 7;
  localparam int AW  = 8;
  localparam int DW  = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata;
  logic [NCH-1:0] irq_pin = '0;
  logic [NCH-1:0] irq_req;

  always #10 clk = ~clk;

  ext_irq_cond #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .irq_pin(irq_pin), .irq_req(irq_req)
  );

  int errs = 0;
  int checks = 0;
  bit cmp_on = 1'b0;
  bit finished = 1'b0;

  // behavioural reference state
  int m_s1[NCH], m_s2[NCH], m_prev[NCH], m_pend[NCH], m_mode[NCH];

  function automatic int exp_irq(int c);
    if (m_mode[c] == 0) return m_s2[c];
    if (m_mode[c] == 1) return 1 - m_s2[c];
    return m_pend[c];
  endfunction

  function automatic logic [DW-1:0] exp_vec_irq();
    logic [DW-1:0] v = '0;
    for (int c = 0; c < NCH; c++) v[c] = exp_irq(c)[0];
    return v;
  endfunction

  function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a);
    logic [DW-1:0] v = '0;
    case (a)
      8'h00: for (int c = 0; c < NCH; c++) v = v | (DW'(m_mode[c]) << (2*c));
      8'h08: v = exp_vec_irq();
      8'h0C: for (int c = 0; c < NCH; c++) v[c] = m_s2[c][0];
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_s1[c] = 0; m_s2[c] = 0; m_prev[c] = 0; m_pend[c] = 0; m_mode[c] = 0;
      end
    end else begin
      bit wr_mode, wr_clr;
      wr_mode = psel && penable && pwrite && (paddr == 8'h00);
      wr_clr  = psel && penable && pwrite && (paddr == 8'h04);
      for (int c = 0; c < NCH; c++) begin
        int nm;
        bit hit, chg, clr;
        nm  = int'((pwdata >> (2*c)) & 3);
        hit = (m_mode[c] == 2 && m_s2[c] == 1 && m_prev[c] == 0) ||
              (m_mode[c] == 3 && m_s2[c] == 0 && m_prev[c] == 1);
        chg = wr_mode && (nm != m_mode[c]);
        clr = wr_clr && pwdata[c];
        if (chg) m_pend[c] = 0;
        else if (hit) m_pend[c] = 1;
        else if (clr) m_pend[c] = 0;
        m_prev[c] = m_s2[c];
        m_s2[c]   = m_s1[c];
        m_s1[c]   = int'(irq_pin[c]);
        if (wr_mode) m_mode[c] = nm;
      end
    end
  end

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      for (int c = 0; c < NCH; c++) begin
        string tag;
        case (m_mode[c])
          0: tag = "R3 high level";
          1: tag = "R4 low level";
          2: tag = "R5 rising edge";
          default: tag = "R6 falling edge";
        endcase
        check(tag, DW'(irq_req[c]), DW'(exp_irq(c)));
      end
    end
  end

  task automatic apb_write(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(logic [AW-1:0] a, output logic [DW-1:0] d, output logic [DW-1:0] e);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #5;
    d = prdata;
    e = exp_read(a);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic read_check(string tag, logic [AW-1:0] a);
    logic [DW-1:0] d, e;
    apb_read(a, d, e);
    check(tag, d, e);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    cmp_on = 1'b1;

    // R1: reset state
    check("R1 irq after reset", DW'(irq_req), '0);
    apb_read(8'h00, d, e); check("R1 mode after reset", d, 32'h0);
    apb_read(8'h08, d, e); check("R1 pending after reset", d, 32'h0);

    // R2: two-edge latency in high-level mode
    @(negedge clk);
    irq_pin[0] = 1'b1;
    @(negedge clk); check("R2 one edge", DW'(irq_req[0]), 32'h0);
    @(negedge clk); check("R2 two edges", DW'(irq_req[0]), 32'h1);
    read_check("R2 raw register", 8'h0C);

    // R3: high level under varying pins
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); irq_pin = NCH'($urandom);
    end
    idle(3);
    read_check("R2 raw after pattern", 8'h0C);
    read_check("R10 pending equals outputs", 8'h08);

    // R4: all low level
    apb_write(8'h00, 32'h1555);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); irq_pin = NCH'($urandom);
    end
    idle(3);
    read_check("R4 pending in low mode", 8'h08);

    // R5: rising edge on channel 0, exact cycles
    irq_pin = '0;
    apb_write(8'h00, 32'h2AAA);
    idle(3);
    apb_write(8'h04, 32'h7F);
    idle(2);
    irq_pin[0] = 1'b1;
    @(negedge clk); check("R5 edge +1", DW'(irq_req[0]), 32'h0);
    @(negedge clk); check("R5 edge +2", DW'(irq_req[0]), 32'h0);
    @(negedge clk); check("R5 edge +3", DW'(irq_req[0]), 32'h1);
    irq_pin[0] = 1'b0;
    idle(4);
    check("R5 sticky after pin falls", DW'(irq_req[0]), 32'h1);

    // R7: clear only channel 0 while channel 1 is pending
    irq_pin[1] = 1'b1;
    idle(4);
    apb_write(8'h04, 32'h01);
    check("R7 cleared channel", DW'(irq_req[0]), 32'h0);
    check("R7 other channel kept", DW'(irq_req[1]), 32'h1);
    read_check("R7 clear reads zero", 8'h04);
    apb_write(8'h04, 32'h02);
    check("R7 second clear", DW'(irq_req[1]), 32'h0);

    // R8: edge detected in the same cycle as the clear access
    irq_pin = '0;
    idle(4);
    @(negedge clk);
    irq_pin[2] = 1'b1;
    apb_write(8'h04, 32'h04);
    check("R8 edge beats clear", DW'(irq_req[2]), 32'h1);

    // R9: same-value rewrite keeps, changed field clears
    apb_write(8'h00, 32'h2AAA);
    check("R9 same mode keeps pending", DW'(irq_req[2]), 32'h1);
    apb_write(8'h00, 32'h2AAA | (32'h3 << 4));
    check("R9 mode change clears pending", DW'(irq_req[2]), 32'h0);

    // R6: falling edge
    apb_write(8'h00, 32'h3FFF);
    idle(2);
    check("R6 no edge stays low", DW'(irq_req[2]), 32'h0);
    irq_pin[2] = 1'b0;
    idle(3);
    check("R6 falling sets", DW'(irq_req[2]), 32'h1);

    // R11: mode register width and unmapped offsets
    apb_write(8'h00, 32'hFFFF_FFFF);
    read_check("R11 mode upper bits zero", 8'h00);
    read_check("R11 unmapped offset", 8'h10);
    apb_write(8'h00, 32'h1B1B);
    read_check("R11 mixed codes", 8'h00);

    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      irq_pin = NCH'($urandom);
      if (k % 37 == 5)  apb_write(8'h00, DW'($urandom));
      if (k % 23 == 11) apb_write(8'h04, DW'($urandom));
      if (k % 41 == 17) read_check("R10 pending random", 8'h08);
      if (k % 43 == 19) read_check("R2 raw random", 8'h0C);
    end
    idle(3);

    finished = 1'b1;
    cmp_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule